// File: doc/BRIEF.md
# Inverter Open-Switch Fault Detector

This block watches a three-phase, two-level inverter and reports open-circuit failures of any of its six power switches. Each phase leg has an upper and a lower gate command, a current-direction bit, and the block receives two measured line-to-line voltages (between legs a and b, and between legs b and c). Each voltage has already been sliced by external comparators into one of three levels. The third line voltage (c to a) is derived inside the block as the negated sum of the two measured ones.

Some cycles after every gate change, the block takes one sample. It predicts each line voltage from the gate pattern. Where the measurement disagrees, it works out which switch failures could explain the error. A failure can only appear as a leg pole stuck at the level of the freewheeling diode that the current direction forces, so it tests every combination of such failures against all usable lines. A switch is accused only when every consistent explanation includes it. A per-switch confirmation counter then turns repeated accusations into a sticky fault flag, which stays set until a synchronous clear.

A drive controller uses the flag vector to start its reconfiguration. The one-cycle valid pulse tells it that a new flag has just been set.

Top module: `osw_fault_monitor`

## Requirements
- R1: After reset, `fault_vec` is all zero and `fault_vld` is low.
- R2: Voltage codes are 2'b01 for +Vdc, 2'b00 for zero and 2'b11 for -Vdc. Bits [2:0] of `fault_vec` stand for the upper switches of legs a, b, c and bits [5:3] for the lower switches of legs a, b, c.
- R3: Exactly one sample is taken per change of the gate inputs. Its decision is registered at the SETTLE_CYC-th rising edge after the edge that first sees the new gates. No further sample is taken while the gates hold still.
- R4: An upper switch is accused only while its upper gate is high, its lower gate is low and its current is positive (`cur_pos`=1). An open upper switch under these conditions is flagged.
- R5: A lower switch is accused only while its lower gate is high, its upper gate is low and its current is negative (`cur_pos`=0). An open lower switch under these conditions is flagged.
- R6: A flag is set at the CONFIRM-th consecutive accusing sample of that switch (default 2). A sample in which the switch could have shown its fault but did not restarts its count.
- R7: Several simultaneous open switches, in the same or in different legs, are each flagged independently.
- R8: A leg whose two gates are equal (dead time) contributes no line comparison. Lines touching it are ignored.
- R9: The illegal code 2'b10 on a sensor removes every line comparison that uses that sensor. The derived c-to-a line is still compared when leg b alone is in dead time.
- R10: Flags are sticky until `clr`. `clr` zeroes all flags and counts at the next edge and takes precedence over a sample in the same cycle.
- R11: `fault_vld` is high for exactly one cycle, the cycle after one or more flags newly set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all fault flags and counts |
| gate_up | input | 3 | Upper gate commands, legs a, b, c |
| gate_dn | input | 3 | Lower gate commands, legs a, b, c |
| cur_pos | input | 3 | Phase current direction, 1 = positive, legs a, b, c |
| v_ab | input | 2 | Quantized line voltage from leg a to leg b |
| v_bc | input | 2 | Quantized line voltage from leg b to leg c |
| fault_vec | output | 6 | Sticky open-switch flags (upper a..c, lower a..c) |
| fault_vld | output | 1 | One-cycle pulse when a flag newly sets |

## Verification
A wrong sample timer shows at the ports as a flag that appears one or more edges away from the SETTLE_CYC-th edge after a gate change. It can also show as an extra `fault_vld` pulse while the gates hold still. A wrong explanation search shows as a flag on a healthy switch or a missing flag. This becomes visible within CONFIRM sampling events of the pattern that exposes it. A wrong confirmation count shows as a flag after a single accusing sample, or as one that survives a healthy sample in between.

// File: rtl/osw_pkg.sv
package osw_pkg;
  localparam int NLEG = 3;
  localparam int NSW  = 2 * NLEG;
  localparam int NHYP = 1 << NLEG;

  typedef logic signed [2:0] lvl_t;

  localparam logic [1:0] LV_POS  = 2'b01;
  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_NEG  = 2'b11;
  localparam logic [1:0] LV_BAD  = 2'b10;

  function automatic lvl_t lvl_dec(input logic [1:0] code);
    case (code)
      LV_POS:  return 3'sd1;
      LV_NEG:  return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic logic lvl_ok(input logic [1:0] code);
    return code != LV_BAD;
  endfunction
endpackage

// File: rtl/osw_settle_timer.sv
module osw_settle_timer import osw_pkg::*; #(
  parameter int SETTLE_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLEG-1:0] gate_up,
  input  logic [NLEG-1:0] gate_dn,
  output logic            smp_stb
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [NSW-1:0] gate_prev;
  logic [CW-1:0]  wait_cnt;
  logic           moved;

  assign moved   = {gate_dn, gate_up} != gate_prev;
  assign smp_stb = (wait_cnt == CW'(1)) && !moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev <= '0;
      wait_cnt  <= '0;
    end else begin
      gate_prev <= {gate_dn, gate_up};
      if (moved)
        wait_cnt <= CW'(SETTLE_CYC);
      else if (wait_cnt != '0)
        wait_cnt <= wait_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/osw_diagnose.sv
module osw_diagnose import osw_pkg::*; (
  input  logic [NLEG-1:0] gate_up,
  input  logic [NLEG-1:0] gate_dn,
  input  logic [NLEG-1:0] cur_pos,
  input  logic [1:0]      v_ab,
  input  logic [1:0]      v_bc,
  output logic [NLEG-1:0] blame_up,
  output logic [NLEG-1:0] blame_dn,
  output logic [NLEG-1:0] seen_up,
  output logic [NLEG-1:0] seen_dn
);
  logic [NLEG-1:0] leg_ok, cand_up, cand_dn, cand, covered, watched;
  lvl_t            pole [NLEG];
  lvl_t            sgn  [NLEG];
  lvl_t            m_ab, m_bc, m_ca;
  lvl_t            err_ab, err_bc, err_ca;
  logic [2:0]      line_ok;
  logic            any_mis, found;
  logic [NHYP-1:0] cons;

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    assign leg_ok[k]  = gate_up[k] ^ gate_dn[k];
    assign cand_up[k] = leg_ok[k] & gate_up[k] & cur_pos[k];
    assign cand_dn[k] = leg_ok[k] & gate_dn[k] & ~cur_pos[k];
    assign cand[k]    = cand_up[k] | cand_dn[k];
    assign pole[k]    = gate_up[k] ? 3'sd1 : 3'sd0;
    // a failure pulls an upper-driven pole down, a lower-driven pole up
    assign sgn[k]     = gate_up[k] ? -3'sd1 : 3'sd1;
  end

  assign m_ab = lvl_dec(v_ab);
  assign m_bc = lvl_dec(v_bc);
  assign m_ca = -(m_ab + m_bc);

  assign err_ab = m_ab - (pole[0] - pole[1]);
  assign err_bc = m_bc - (pole[1] - pole[2]);
  assign err_ca = m_ca - (pole[2] - pole[0]);

  assign line_ok[0] = leg_ok[0] & leg_ok[1] & lvl_ok(v_ab);
  assign line_ok[1] = leg_ok[1] & leg_ok[2] & lvl_ok(v_bc);
  assign line_ok[2] = leg_ok[2] & leg_ok[0] & lvl_ok(v_ab) & lvl_ok(v_bc)
                    & (m_ca >= -3'sd1) & (m_ca <= 3'sd1);

  assign any_mis = (line_ok[0] && err_ab != 3'sd0) ||
                   (line_ok[1] && err_bc != 3'sd0) ||
                   (line_ok[2] && err_ca != 3'sd0);

  // every set of failing legs is tested against every usable line
  for (genvar h = 0; h < NHYP; h++) begin : g_hyp
    localparam logic [NLEG-1:0] HM = NLEG'(h);
    lvl_t ea, eb, ec;
    assign ea = HM[0] ? sgn[0] : 3'sd0;
    assign eb = HM[1] ? sgn[1] : 3'sd0;
    assign ec = HM[2] ? sgn[2] : 3'sd0;
    assign cons[h] = ((HM & ~cand) == '0)
                   && (!line_ok[0] || (ea - eb) == err_ab)
                   && (!line_ok[1] || (eb - ec) == err_bc)
                   && (!line_ok[2] || (ec - ea) == err_ca);
  end

  always_comb begin
    for (int k = 0; k < NLEG; k++) begin
      covered[k] = 1'b1;
      for (int h = 0; h < NHYP; h++)
        if (cons[h] && (((h >> k) & 1) == 0))
          covered[k] = 1'b0;
    end
  end

  assign found = |cons;

  assign watched[0] = line_ok[0] | line_ok[2];
  assign watched[1] = line_ok[0] | line_ok[1];
  assign watched[2] = line_ok[1] | line_ok[2];

  assign blame_up = {NLEG{any_mis & found}} & covered & cand_up;
  assign blame_dn = {NLEG{any_mis & found}} & covered & cand_dn;
  assign seen_up  = cand_up & watched;
  assign seen_dn  = cand_dn & watched;
endmodule

// File: rtl/osw_confirm.sv
module osw_confirm import osw_pkg::*; #(
  parameter int CONFIRM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           smp_stb,
  input  logic [NSW-1:0] hit,
  input  logic [NSW-1:0] seen,
  output logic [NSW-1:0] fault_vec,
  output logic           fault_vld
);
  localparam int CW = $clog2(CONFIRM + 1);

  logic [NSW-1:0] set_now;

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    logic [CW-1:0] run;
    logic          flag;

    assign set_now[i]   = smp_stb & seen[i] & hit[i] & ~flag
                        & (run == CW'(CONFIRM - 1));
    assign fault_vec[i] = flag;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        run  <= '0;
        flag <= 1'b0;
      end else begin
        if (set_now[i])
          flag <= 1'b1;
        if (smp_stb && seen[i]) begin
          if (!hit[i])
            run <= '0;
          else if (run != CW'(CONFIRM))
            run <= run + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      fault_vld <= 1'b0;
    else
      fault_vld <= |set_now;
  end
endmodule

// File: rtl/osw_fault_monitor.sv
module osw_fault_monitor import osw_pkg::*; #(
  parameter int SETTLE_CYC = 4,
  parameter int CONFIRM    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [2:0] gate_up,
  input  logic [2:0] gate_dn,
  input  logic [2:0] cur_pos,
  input  logic [1:0] v_ab,
  input  logic [1:0] v_bc,
  output logic [5:0] fault_vec,
  output logic       fault_vld
);
  logic            smp_stb;
  logic [NLEG-1:0] hit_up, hit_dn, seen_up, seen_dn;

  osw_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .gate_up(gate_up), .gate_dn(gate_dn),
    .smp_stb(smp_stb)
  );

  osw_diagnose u_diag (
    .gate_up(gate_up), .gate_dn(gate_dn), .cur_pos(cur_pos),
    .v_ab(v_ab), .v_bc(v_bc),
    .blame_up(hit_up), .blame_dn(hit_dn),
    .seen_up(seen_up), .seen_dn(seen_dn)
  );

  osw_confirm #(.CONFIRM(CONFIRM)) u_conf (
    .clk(clk), .rst(rst), .clr(clr), .smp_stb(smp_stb),
    .hit({hit_dn, hit_up}), .seen({seen_dn, seen_up}),
    .fault_vec(fault_vec), .fault_vld(fault_vld)
  );
endmodule

// File: rtl/osw_checks.sv
module osw_checks (
  input logic       clk,
  input logic       rst,
  input logic       clr,
  input logic [2:0] gate_up,
  input logic [2:0] gate_dn,
  input logic [2:0] cur_pos,
  input logic [5:0] fault_vec,
  input logic       fault_vld,
  input logic       smp_stb,
  input logic [2:0] hit_up,
  input logic [2:0] hit_dn
);
  AST_UP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (hit_up & ~(gate_up & ~gate_dn & cur_pos)) == 3'b000); // R4
  AST_DN_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (hit_dn & ~(gate_dn & ~gate_up & ~cur_pos)) == 3'b000); // R5
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb); // R3
  AST_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    ((fault_vec & ~$past(fault_vec)) != 6'b0) |-> ($past(smp_stb) && !$past(clr))); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((fault_vec & $past(fault_vec)) == $past(fault_vec))); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fault_vec == 6'b0 && !fault_vld)); // R10
  AST_VLD_ON_NEW: assert property (@(posedge clk) disable iff (rst)
    ((fault_vec & ~$past(fault_vec)) != 6'b0) |-> fault_vld); // R11
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_vld |=> !fault_vld); // R11
endmodule

bind osw_fault_monitor osw_checks u_chk (
  .clk(clk), .rst(rst), .clr(clr), .gate_up(gate_up), .gate_dn(gate_dn),
  .cur_pos(cur_pos), .fault_vec(fault_vec), .fault_vld(fault_vld),
  .smp_stb(smp_stb), .hit_up(hit_up), .hit_dn(hit_dn)
);

// File: tb/sim_osw_fault_monitor.sv
`timescale 1ns/1ps
module sim_osw_fault_monitor;
  localparam int SET = 4;
  localparam int WD_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic [2:0] gate_up = '0, gate_dn = '0, cur_pos = '0;
  logic [1:0] v_ab = '0, v_bc = '0;
  logic [5:0] fault_vec;
  logic       fault_vld;

  logic [2:0] open_up = '0, open_dn = '0;
  int tests = 0, fails = 0, vld_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  osw_fault_monitor #(.SETTLE_CYC(SET), .CONFIRM(2)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .gate_up(gate_up), .gate_dn(gate_dn),
    .cur_pos(cur_pos), .v_ab(v_ab), .v_bc(v_bc),
    .fault_vec(fault_vec), .fault_vld(fault_vld)
  );

  always @(negedge clk) if (!rst && fault_vld) vld_seen++;

  function automatic logic [1:0] enc(input int v);
    case (v)
      1:       return 2'b01;
      0:       return 2'b00;
      -1:      return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  // switching plant: poles forced by diodes when a switch is open or in dead time
  function automatic logic [3:0] plant(input logic [2:0] u, d, p);
    int pl [3];
    for (int k = 0; k < 3; k++) begin
      if (u[k] && !d[k])      pl[k] = (open_up[k] && p[k]) ? 0 : 1;
      else if (d[k] && !u[k]) pl[k] = (open_dn[k] && !p[k]) ? 1 : 0;
      else                    pl[k] = p[k] ? 0 : 1;
    end
    return {enc(pl[0] - pl[1]), enc(pl[1] - pl[2])};
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_n(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] u, d, p, input logic [1:0] ab, bc);
    gate_up = u; gate_dn = d; cur_pos = p; v_ab = ab; v_bc = bc;
  endtask

  task automatic drive_raw(input logic [2:0] u, d, p, input logic [1:0] ab, bc);
    put(u, d, p, ab, bc);
    repeat (SET + 2) @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] u, d, p);
    logic [3:0] v;
    v = plant(u, d, p);
    drive_raw(u, d, p, v[3:2], v[1:0]);
  endtask

  task automatic step(input logic [2:0] u, p);
    drive(u, ~u, p);
    drive(3'b000, 3'b000, p);
  endtask

  task automatic start(input logic [2:0] ou, od);
    open_up = ou; open_dn = od;
    drive(3'b000, 3'b000, 3'b000);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    vld_seen = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags after reset", fault_vec, 6'b0);
    chk_n("R1 valid after reset", fault_vld, 0);
  endtask

  task automatic t_codes();
    start(3'b000, 3'b000);
    // leg a high, b/c low, all currents positive: ab must read +Vdc (01)
    repeat (2) begin
      drive_raw(3'b001, 3'b110, 3'b111, 2'b01, 2'b00);
      drive_raw(3'b000, 3'b000, 3'b111, 2'b00, 2'b00);
    end
    chk("R2 code 01 is +Vdc, no flag", fault_vec, 6'b0);
    repeat (2) begin
      drive_raw(3'b001, 3'b110, 3'b111, 2'b00, 2'b00);
      drive_raw(3'b000, 3'b000, 3'b111, 2'b00, 2'b00);
    end
    chk("R2 code 00 on ab flags upper a at bit 0", fault_vec, 6'b000001);
  endtask

  task automatic t_healthy();
    start(3'b000, 3'b000);
    repeat (2) begin
      step(3'b011, 3'b101);
      step(3'b110, 3'b010);
      step(3'b100, 3'b001);
      step(3'b111, 3'b011);
    end
    chk("R2 healthy patterns give no flag", fault_vec, 6'b0);
    chk_n("R11 healthy gives no valid pulse", vld_seen, 0);
  endtask

  task automatic t_upper();
    start(3'b001, 3'b000);
    step(3'b011, 3'b011);
    chk("R6 single accusation does not flag", fault_vec, 6'b0);
    step(3'b011, 3'b011);
    chk("R4 open upper a flagged", fault_vec, 6'b000001);
    chk_n("R11 one valid pulse", vld_seen, 1);
  endtask

  task automatic t_unqualified();
    start(3'b001, 3'b000);
    repeat (3) step(3'b011, 3'b010);
    chk("R4 open upper with negative current unseen", fault_vec, 6'b0);
  endtask

  task automatic t_lower();
    start(3'b000, 3'b010);
    step(3'b001, 3'b101);
    step(3'b001, 3'b101);
    chk("R5 open lower b flagged at bit 4", fault_vec, 6'b010000);
  endtask

  task automatic t_multi();
    start(3'b001, 3'b010);
    step(3'b101, 3'b101);
    step(3'b101, 3'b101);
    chk("R7 upper a and lower b both flagged", fault_vec, 6'b010001);
  endtask

  task automatic t_sticky_clear();
    open_up = 3'b000; open_dn = 3'b000;
    step(3'b101, 3'b101);
    step(3'b011, 3'b011);
    chk("R10 flags stay through healthy samples", fault_vec, 6'b010001);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 clear zeroes flags", fault_vec, 6'b0);
    chk_n("R10 clear drops valid", fault_vld, 0);
  endtask

  task automatic t_interleave();
    start(3'b001, 3'b000);
    step(3'b011, 3'b011);
    open_up = 3'b000;
    step(3'b011, 3'b011);
    open_up = 3'b001;
    step(3'b011, 3'b011);
    chk("R6 healthy sample restarts count", fault_vec, 6'b0);
    step(3'b011, 3'b011);
    chk("R6 second consecutive accusation flags", fault_vec, 6'b000001);
  endtask

  task automatic t_settle();
    logic [3:0] v;
    start(3'b001, 3'b000);
    step(3'b011, 3'b011);
    v = plant(3'b011, 3'b100, 3'b011);
    put(3'b011, 3'b100, 3'b011, v[3:2], v[1:0]);
    repeat (SET) @(negedge clk);
    chk("R3 no decision before settle edge", fault_vec, 6'b0);
    @(negedge clk);
    chk("R3 decision at settle edge", fault_vec, 6'b000001);
    chk_n("R11 valid right after set", fault_vld, 1);
    @(negedge clk);
    chk_n("R11 valid lasts one cycle", fault_vld, 0);
    // clear while the mismatching pattern holds: no new sample may occur
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 steady gates give no further sample", fault_vec, 6'b0);
  endtask

  task automatic t_dead();
    start(3'b000, 3'b000);
    // leg b in dead time with its pole pulled high: ab/bc look wrong but are ignored
    repeat (2) begin
      drive(3'b101, 3'b000, 3'b101);
      drive(3'b000, 3'b000, 3'b101);
    end
    chk("R8 dead-time leg lines ignored", fault_vec, 6'b0);
    start(3'b001, 3'b000);
    repeat (2) begin
      drive(3'b001, 3'b100, 3'b101);
      drive(3'b000, 3'b000, 3'b101);
    end
    chk("R9 derived ca line flags upper a", fault_vec, 6'b000001);
  endtask

  task automatic t_illegal();
    logic [3:0] v;
    start(3'b001, 3'b000);
    v = plant(3'b011, 3'b100, 3'b011);
    repeat (3) begin
      drive_raw(3'b011, 3'b100, 3'b011, 2'b10, v[1:0]);
      drive_raw(3'b000, 3'b000, 3'b011, 2'b10, 2'b00);
    end
    chk("R9 illegal ab code suppresses its lines", fault_vec, 6'b0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_codes();
    t_healthy();
    t_upper();
    t_unqualified();
    t_lower();
    t_multi();
    t_sticky_clear();
    t_interleave();
    t_settle();
    t_dead();
    t_illegal();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end
endmodule